// File: doc/BRIEF.md
# Power-Controller Host Register Target (I2C)

This block lets a host controller reach a Type-C power controller over a two-wire I2C bus. It answers to one fixed 7-bit address. A write transfer sets an internal register pointer and then stores any number of data bytes, moving the pointer forward after each one. A read transfer first sets the pointer with a short write. A repeated START follows, and the block then returns bytes from consecutive locations until the host refuses a byte.

The register space is sparse. It holds two host-writable control bytes and three read-only status bytes, which the surrounding power logic drives. It also holds two interrupt bytes. Each interrupt bit catches a one-cycle event pulse and stays set until the host writes to that byte. An active-low interrupt line tells the host that at least one bit is pending. SCL and SDA are oversampled on the system clock through a two-flop synchronizer. The bus side is a single state machine with these states:

- `ST_IDLE`, `ST_ADDR`, `ST_ADDR_ACK`, `ST_PTR`, `ST_PTR_ACK`, `ST_WDATA`, `ST_WDATA_ACK`, `ST_RDATA`, `ST_RDATA_ACK`.

State transitions:

- A START in any state goes to `ST_ADDR`, and a STOP in any state goes to `ST_IDLE`.
- On the SCL fall after eight address bits, `ST_ADDR` goes to `ST_ADDR_ACK` on a match and to `ST_IDLE` otherwise.
- `ST_ADDR_ACK` goes to `ST_PTR` for a write or to `ST_RDATA` for a read.
- `ST_PTR` goes to `ST_PTR_ACK`, then to `ST_WDATA`.
- `ST_WDATA` and `ST_WDATA_ACK` alternate, one pair per byte.
- `ST_RDATA` goes to `ST_RDATA_ACK`.
- `ST_RDATA_ACK` returns to `ST_RDATA` on a host ACK, or goes to `ST_IDLE` on a host NACK.

Top module: `pdi2c_target`

## Requirements
- R1: The block acknowledges only the 7-bit address 7'b1000001 (byte 8'h82 to write, 8'h83 to read). For any other address the block leaves SDA released through the ACK slot and the rest of the transfer, and no register changes.
- R2: In a write, the first byte after the address sets the register pointer. Every later byte is stored at the pointer, and the pointer then advances by one. The block ACKs the pointer byte and every data byte.
- R3: After a pointer write, a repeated START and the read address, the block returns the byte at the pointer. The pointer advances after each byte. Output continues while the host ACKs. After the host NACKs, SDA is released.
- R4: The locations are:

  | Address | Register |
  |---------|----------|
  | 8'h00 | Control A |
  | 8'h01 | Control B |
  | 8'h02 | Status A |
  | 8'h03 | Status B |
  | 8'h06 | Interrupt A |
  | 8'h07 | Interrupt B |
  | 8'h0C | Status C |

  Control reads return the last written value. Status reads return the live status input.
- R5: Writes to status locations and to unmapped locations have no effect. Unmapped locations read as 8'h00.
- R6: After reset, both control bytes and both interrupt bytes are 0, and the interrupt line is high.
- R7: A high bit on an event input sets the matching interrupt bit on the next clock edge. Bits accumulate, and a bit stays set, through reads, until a host write to its byte.
- R8: A host write to an interrupt byte clears every bit of that byte, whatever the data. The other interrupt byte is not affected.
- R9: An event that arrives in the same cycle as the clearing write wins: that bit stays set, and the interrupt line does not release.
- R10: The interrupt line is low exactly while at least one bit of either interrupt byte is 1.
- R11: The block only pulls SDA low and never drives it high. It changes its SDA drive only in response to a falling SCL edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low; when 0, SDA is released |
| ctrl0_o | output | 8 | Control A byte |
| ctrl1_o | output | 8 | Control B byte |
| stat0_i | input | 8 | Status A byte |
| stat1_i | input | 8 | Status B byte: bit 7 flags a capability mismatch; bits 1:0 give the swap result (00 none, 01 accepted, 10 wait, 11 rejected) |
| stat2_i | input | 8 | Status C byte, bit by bit: 6 = CC line in use; 5:4 = partner current level; 3 = host-side partner present; 2 = device-side partner present; 1 = attach; 0 = detach |
| irq0_evt_i | input | 8 | Event pulses for Interrupt A, bit by bit: 7 = contract made; 6 = current level changed; 5 = power transition request; 4 = VCONN swap; 3 = power role swap; 2 = data role swap; 1 = attach; 0 = detach |
| irq1_evt_i | input | 8 | Event pulses for Interrupt B |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
Some rules are checked on every cycle by the bound checker:
- SDA drive changes only after a sampled SCL fall.
- The control bytes hold unless a write targets them.
- Interrupt bits never drop without a write to their byte.
- Any event drives the interrupt line low on the next cycle.
- A clearing write leaves an interrupt byte equal to exactly the events of that cycle.

Other behaviour can only be shown by the bench's bus transfers:
- the address match and the NACK of foreign addresses;
- the pointer handling across byte bursts and repeated STARTs;
- the content of the sparse map, including unmapped locations and status writes that must be ignored;
- the release of SDA after a host NACK.

// File: rtl/pdi2c_pkg.sv
package pdi2c_pkg;

    // Bus-side protocol states
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } tgt_state_t;

    localparam int BYTE_W   = 8;
    localparam int BIT_CW   = $clog2(BYTE_W + 1);
    localparam int NUM_IRQ  = 2;
    localparam int IRQ_W    = NUM_IRQ * BYTE_W;

    // Register locations
    localparam logic [7:0] REG_CTRL0    = 8'h00;
    localparam logic [7:0] REG_CTRL1    = 8'h01;
    localparam logic [7:0] REG_STAT0    = 8'h02;
    localparam logic [7:0] REG_STAT1    = 8'h03;
    localparam logic [7:0] REG_IRQ_BASE = 8'h06;
    localparam logic [7:0] REG_STAT2    = 8'h0C;

endpackage

// File: rtl/pdi2c_line_sync.sv
module pdi2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;

    // Bus idles high, so all stages reset to 1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_p  <= 1'b1;
            sda_p  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_p  <= scl_sh[STAGES-1];
            sda_p  <= sda_sh[STAGES-1];
        end
    end

    assign scl_s     = scl_sh[STAGES-1];
    assign sda_s     = sda_sh[STAGES-1];
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/pdi2c_tgt_fsm.sv
module pdi2c_tgt_fsm
    import pdi2c_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR = 7'b1000001
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_s,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic [7:0] reg_ptr,
    output logic       wr_en,
    output logic [7:0] wr_data
);
    tgt_state_t        state, nxt;
    logic [7:0]        shreg;
    logic [7:0]        txsr;
    logic [BIT_CW-1:0] bitcnt;
    logic              mnack;
    logic              byte_done;
    logic              addr_hit;
    logic              rx_state;
    logic              bus_evt;

    assign byte_done = (bitcnt == BIT_CW'(BYTE_W));
    assign addr_hit  = (shreg[7:1] == TGT_ADDR);
    assign rx_state  = (state == ST_ADDR) || (state == ST_PTR) || (state == ST_WDATA);
    assign bus_evt   = start_det || stop_det;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_ADDR:      if (scl_fall && byte_done) nxt = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK:  if (scl_fall) nxt = shreg[0] ? ST_RDATA : ST_PTR;
                ST_PTR:       if (scl_fall && byte_done) nxt = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_fall) nxt = ST_WDATA;
                ST_WDATA:     if (scl_fall && byte_done) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) nxt = ST_WDATA;
                ST_RDATA:     if (scl_fall && byte_done) nxt = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall) nxt = mnack ? ST_IDLE : ST_RDATA;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // Shift, bit count and pointer datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            txsr    <= '0;
            bitcnt  <= '0;
            mnack   <= 1'b0;
            reg_ptr <= '0;
        end else if (bus_evt) begin
            bitcnt <= '0;
        end else begin
            if (scl_rise && rx_state && !byte_done) begin
                shreg  <= {shreg[6:0], sda_s};
                bitcnt <= bitcnt + 1'b1;
            end
            if (scl_rise && state == ST_RDATA && !byte_done)
                bitcnt <= bitcnt + 1'b1;
            if (scl_rise && state == ST_RDATA_ACK)
                mnack <= sda_s;
            if (scl_fall) begin
                if (rx_state && byte_done)
                    bitcnt <= '0;
                if (state == ST_PTR && byte_done)
                    reg_ptr <= shreg;
                if (state == ST_WDATA && byte_done)
                    reg_ptr <= reg_ptr + 8'd1;
                if ((state == ST_ADDR_ACK && shreg[0]) ||
                    (state == ST_RDATA_ACK && !mnack)) begin
                    txsr    <= rd_data;
                    reg_ptr <= reg_ptr + 8'd1;
                end
                if (state == ST_RDATA) begin
                    if (byte_done) bitcnt <= '0;
                    else           txsr   <= {txsr[6:0], 1'b0};
                end
            end
        end
    end

    assign wr_en   = (state == ST_WDATA) && scl_fall && byte_done && !bus_evt;
    assign wr_data = shreg;

    // Output logic: open-drain pull-down only
    always_comb begin
        unique case (state)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA:                              sda_oe = ~txsr[7];
            default:                               sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/pdi2c_regbank.sv
module pdi2c_regbank
    import pdi2c_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       reg_ptr,
    input  logic [7:0]       wr_data,
    input  logic [7:0]       stat0_i,
    input  logic [7:0]       stat1_i,
    input  logic [7:0]       stat2_i,
    input  logic [IRQ_W-1:0] evt_i,
    output logic [7:0]       ctrl0_o,
    output logic [7:0]       ctrl1_o,
    output logic [IRQ_W-1:0] irq_flags_o,
    output logic [7:0]       rd_data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl0_o <= '0;
            ctrl1_o <= '0;
        end else if (wr_en) begin
            if (reg_ptr == REG_CTRL0) ctrl0_o <= wr_data;
            if (reg_ptr == REG_CTRL1) ctrl1_o <= wr_data;
        end
    end

    // Interrupt bytes: a write clears, a same-cycle event re-sets
    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_irq
        logic [7:0] flags;
        logic       clr;
        assign clr = wr_en && (reg_ptr == REG_IRQ_BASE + 8'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags <= '0;
            else        flags <= (clr ? 8'h00 : flags) | evt_i[g*BYTE_W +: BYTE_W];
        end
        assign irq_flags_o[g*BYTE_W +: BYTE_W] = flags;
    end

    always_comb begin
        rd_data = 8'h00;
        case (reg_ptr)
            REG_CTRL0: rd_data = ctrl0_o;
            REG_CTRL1: rd_data = ctrl1_o;
            REG_STAT0: rd_data = stat0_i;
            REG_STAT1: rd_data = stat1_i;
            REG_STAT2: rd_data = stat2_i;
            default:   rd_data = 8'h00;
        endcase
        for (int g = 0; g < NUM_IRQ; g++)
            if (reg_ptr == REG_IRQ_BASE + 8'(g))
                rd_data = irq_flags_o[g*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/pdi2c_target.sv
module pdi2c_target
    import pdi2c_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR    = 7'b1000001,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    output logic [7:0] ctrl0_o,
    output logic [7:0] ctrl1_o,
    input  logic [7:0] stat0_i,
    input  logic [7:0] stat1_i,
    input  logic [7:0] stat2_i,
    input  logic [7:0] irq0_evt_i,
    input  logic [7:0] irq1_evt_i,
    output logic       irq_n_o
);
    logic             sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en;
    logic [7:0]       reg_ptr, wr_data, rd_data;
    logic [IRQ_W-1:0] irq_flags;
    logic [IRQ_W-1:0] evt_flags;

    assign evt_flags = {irq1_evt_i, irq0_evt_i};

    pdi2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    pdi2c_tgt_fsm #(.TGT_ADDR(TGT_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe_o),
        .reg_ptr   (reg_ptr),
        .wr_en     (wr_en),
        .wr_data   (wr_data)
    );

    pdi2c_regbank u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .reg_ptr     (reg_ptr),
        .wr_data     (wr_data),
        .stat0_i     (stat0_i),
        .stat1_i     (stat1_i),
        .stat2_i     (stat2_i),
        .evt_i       (evt_flags),
        .ctrl0_o     (ctrl0_o),
        .ctrl1_o     (ctrl1_o),
        .irq_flags_o (irq_flags),
        .rd_data     (rd_data)
    );

    assign irq_n_o = ~(|irq_flags);

endmodule

// File: rtl/pdi2c_checker.sv
module pdi2c_checker
    import pdi2c_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl_fall,
    input logic             sda_oe,
    input logic             wr_en,
    input logic [7:0]       reg_ptr,
    input logic [7:0]       ctrl0,
    input logic [7:0]       ctrl1,
    input logic [IRQ_W-1:0] irq_flags,
    input logic [IRQ_W-1:0] evt_flags,
    input logic             irq_n
);
    logic irq_wr, ctrl_wr, irq0_wr;
    assign irq0_wr = wr_en && (reg_ptr == REG_IRQ_BASE);
    assign irq_wr  = irq0_wr || (wr_en && (reg_ptr == REG_IRQ_BASE + 8'd1));
    assign ctrl_wr = wr_en && ((reg_ptr == REG_CTRL0) || (reg_ptr == REG_CTRL1));

    assert_oe_after_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall));

    assert_ctrl_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable({ctrl1, ctrl0}));

    assert_evt_irq_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_flags != '0) |=> !irq_n);

    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_wr |=> ((irq_flags & $past(irq_flags)) == $past(irq_flags)));

    assert_clear_keeps_evt_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq0_wr |=> (irq_flags[7:0] == $past(evt_flags[7:0])));

endmodule

bind pdi2c_target pdi2c_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_fall  (scl_fall),
    .sda_oe    (sda_oe_o),
    .wr_en     (wr_en),
    .reg_ptr   (reg_ptr),
    .ctrl0     (ctrl0_o),
    .ctrl1     (ctrl1_o),
    .irq_flags (irq_flags),
    .evt_flags (evt_flags),
    .irq_n     (irq_n_o)
);

// File: tb/tb_pdi2c_target.sv
module tb_pdi2c_target;
    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 6;
    localparam logic [6:0] DEV        = 7'b1000001;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic [7:0] stat0 = 8'h96, stat1 = 8'h81, stat2 = 8'h5A;
    logic [7:0] evt0 = 8'h00, evt1 = 8'h00;
    logic       sda_oe, irq_n;
    logic [7:0] ctrl0, ctrl1;
    wire        sda_line;
    assign sda_line = sda_m & ~sda_oe;

    pdi2c_target dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .ctrl0_o(ctrl0), .ctrl1_o(ctrl1),
        .stat0_i(stat0), .stat1_i(stat1), .stat2_i(stat2),
        .irq0_evt_i(evt0), .irq1_evt_i(evt1), .irq_n_o(irq_n)
    );

    // Scoreboard queues
    string      exp_req[$];
    logic [7:0] exp_val[$];
    logic [7:0] act_val[$];
    int pushed = 0, done = 0, errors = 0, checks = 0;
    bit finished = 1'b0;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        exp_req.push_back(req);
        exp_val.push_back(exp);
        act_val.push_back(act);
        pushed++;
    endtask

    // Monitor: pops and compares
    initial begin
        string      r;
        logic [7:0] e, a;
        forever begin
            wait (pushed > done);
            r = exp_req.pop_front();
            e = exp_val.pop_front();
            a = act_val.pop_front();
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s: actual=%02h expected=%02h", r, a, e);
            end
            done++;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    int  win_hi = 0;
    bit  mon_win = 1'b0;
    always @(negedge clk) if (mon_win && irq_n) win_hi++;

    task automatic wq(input int n = 1);
        repeat (n*Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic i2c_rstart();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq(2);
    endtask

    task automatic send(input logic [7:0] b, output logic ack_n);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq();
            scl_m = 1'b1; wq(2);
            scl_m = 1'b0;
        end
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        ack_n = sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic recv(input logic nack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            scl_m = 1'b1; wq();
            b[i] = sda_line; wq();
            scl_m = 1'b0;
        end
        sda_m = nack; wq();
        scl_m = 1'b1; wq(2);
        scl_m = 1'b0; wq();
    endtask

    task automatic wr_bytes(input logic [7:0] ptr, input logic [7:0] d0,
                            input logic [7:0] d1, input int n);
        logic a;
        i2c_start();
        send({DEV, 1'b0}, a); chk("R1 address ack on write", {7'd0, a}, 8'h00);
        send(ptr, a);         chk("R2 pointer ack", {7'd0, a}, 8'h00);
        send(d0, a);          chk("R2 data ack", {7'd0, a}, 8'h00);
        if (n > 1) begin
            send(d1, a);      chk("R2 second data ack", {7'd0, a}, 8'h00);
        end
        i2c_stop();
    endtask

    task automatic rd_bytes(input logic [7:0] ptr, input int n, input logic [7:0] e0,
                            input logic [7:0] e1, input logic [7:0] e2, input string req);
        logic       a;
        logic [7:0] b;
        logic [7:0] e;
        i2c_start();
        send({DEV, 1'b0}, a);
        send(ptr, a);
        i2c_rstart();
        send({DEV, 1'b1}, a); chk("R3 address ack on read", {7'd0, a}, 8'h00);
        for (int k = 0; k < n; k++) begin
            recv(k == n-1, b);
            e = (k == 0) ? e0 : ((k == 1) ? e1 : e2);
            chk(req, b, e);
        end
        chk("R3 SDA released after host NACK", {7'd0, sda_oe}, 8'h00);
        i2c_stop();
    endtask

    task automatic pulse(input int which, input logic [7:0] bits);
        @(negedge clk);
        if (which == 0) evt0 = bits; else evt1 = bits;
        @(negedge clk);
        evt0 = 8'h00; evt1 = 8'h00;
    endtask

    initial begin
        logic a;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        wq();
        chk("R6 irq_n high after reset", {7'd0, irq_n}, 8'h01);
        chk("R6 control A reset", ctrl0, 8'h00);
        chk("R6 control B reset", ctrl1, 8'h00);
        chk("R11 SDA released when idle", {7'd0, sda_oe}, 8'h00);
        rd_bytes(8'h06, 2, 8'h00, 8'h00, 8'h00, "R6 interrupt bytes reset");

        // Burst write and readback
        wr_bytes(8'h00, 8'hA5, 8'h3C, 2);
        chk("R2 control A written", ctrl0, 8'hA5);
        chk("R2 control B via auto-increment", ctrl1, 8'h3C);
        rd_bytes(8'h00, 3, 8'hA5, 8'h3C, 8'h96, "R3 R4 burst read control/status A");
        rd_bytes(8'h03, 1, 8'h81, 8'h00, 8'h00, "R4 status B");
        rd_bytes(8'h0B, 3, 8'h00, 8'h5A, 8'h00, "R4 R5 unmapped/status C");

        // Foreign address
        i2c_start();
        send({7'h42, 1'b0}, a); chk("R1 foreign address NACK", {7'd0, a}, 8'h01);
        send(8'h00, a);         chk("R1 no ACK after foreign address", {7'd0, a}, 8'h01);
        send(8'h11, a);
        i2c_stop();
        chk("R1 control A untouched", ctrl0, 8'hA5);

        // Ignored writes
        wr_bytes(8'h02, 8'hFF, 8'hFF, 2);
        rd_bytes(8'h02, 2, 8'h96, 8'h81, 8'h00, "R5 status ignores writes");
        wr_bytes(8'h04, 8'h77, 8'h88, 2);
        chk("R5 control A after unmapped write", ctrl0, 8'hA5);
        chk("R5 control B after unmapped write", ctrl1, 8'h3C);
        rd_bytes(8'h04, 2, 8'h00, 8'h00, 8'h00, "R5 unmapped reads zero");
        wr_bytes(8'h0C, 8'h11, 8'h22, 2);
        rd_bytes(8'h0C, 2, 8'h5A, 8'h00, 8'h00, "R5 status C ignores writes");

        // Interrupt latching
        pulse(0, 8'h02);
        chk("R7 R10 irq_n low after event", {7'd0, irq_n}, 8'h00);
        pulse(0, 8'h80);
        rd_bytes(8'h06, 2, 8'h82, 8'h00, 8'h00, "R7 events accumulate");
        rd_bytes(8'h06, 1, 8'h82, 8'h00, 8'h00, "R7 read does not clear");
        pulse(1, 8'h40);
        rd_bytes(8'h07, 1, 8'h40, 8'h00, 8'h00, "R7 interrupt B latch");
        wr_bytes(8'h06, 8'h00, 8'h00, 1);
        rd_bytes(8'h06, 2, 8'h00, 8'h40, 8'h00, "R8 write clears only its byte");
        chk("R10 irq_n low while B pending", {7'd0, irq_n}, 8'h00);
        wr_bytes(8'h07, 8'hFF, 8'h00, 1);
        chk("R8 R10 irq_n high after all cleared", {7'd0, irq_n}, 8'h01);

        // Event coincident with clear
        @(negedge clk); evt0 = 8'h01;
        wq();
        mon_win = 1'b1;
        i2c_start();
        send({DEV, 1'b0}, a);
        send(8'h06, a);
        send(8'h00, a);
        wq();
        evt0 = 8'h00;
        wq();
        mon_win = 1'b0;
        i2c_stop();
        chk("R9 irq_n never released during clear", 8'(win_hi), 8'h00);
        rd_bytes(8'h06, 1, 8'h01, 8'h00, 8'h00, "R9 event wins over clear");
        wr_bytes(8'h06, 8'h00, 8'h00, 1);
        chk("R8 irq_n high after final clear", {7'd0, irq_n}, 8'h01);
        chk("R11 SDA released at end", {7'd0, sda_oe}, 8'h00);

        wait (done == pushed);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule